// File: doc/BRIEF.md
# Switch-Event Interrupt Peripheral with LED Decoder

This block is a small APB3 slave with a single register location. A write to it drives a bank of LEDs so that exactly one lamp is lit, picked by a binary-to-one-hot decode of the low bits of the written word. A read returns sticky event flags, one per switch input, and clears them in the same access. Software can therefore learn which switch was pressed without polling the raw switch lines.

Each switch input passes through its own register chain clocked by the bus clock. The chain is cleared asynchronously whenever the switch line is low. When a switch has been high long enough for its chain to fill to the second stage but not yet the third, the block sends a single-cycle interrupt pulse. The pulse suits a level-sensitive interrupt input, because it cannot keep that input asserted after the handler has returned. A second interrupt output carries the same pulse, so that two interrupt receivers can be fed from one event.

Top module: `switch_irq_apb`

## Requirements
- R1: While pResetN is low and in the first cycle after it rises, ledOut is 0, pRData is 0, and irqMain and irqCopy are 0.
- R2: A write access (pSel, pEnable and pWrite high at a rising pClk edge) sets ledOut to a one-hot value with bit k lit, where k = pWData[2:0]. Bits above bit 2 of pWData have no effect.
- R3: ledOut holds its value until the next write access. Read accesses and switch events leave it unchanged.
- R4: When a switch input rises between two clock edges and then stays high, irqMain is high during the cycle that follows the third rising edge after the rise, and low before that cycle.
- R5: The interrupt is a single-cycle pulse. Holding a switch high gives no further pulse, and a switch falling gives no pulse.
- R6: A switch line that is low clears its chain asynchronously. A high excursion that covers only one rising edge gives no pulse and sets no flag.
- R7: When both switches complete an event in the same cycle, one single-cycle pulse is produced and both flags are set.
- R8: Flag bit 0 records events of swIn[0] and flag bit 1 records events of swIn[1]. pRData carries the flags in bits 1:0 with all upper bits 0, and a flag stays set until a read clears it.
- R9: A read access returns the flags as they were before the access and clears them to 0 at that access edge.
- R10: When an event completes at the same edge as a clearing read, its flag is set after that edge and is not lost.
- R11: irqCopy equals irqMain in every cycle.
- R12: pReady is always 1 and pSlvErr is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pClk | input | 1 | Bus and peripheral clock |
| pResetN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | APB slave select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB direction, 1 for write |
| pWData | input | 32 | APB write data; low 3 bits select the LED |
| pRData | output | 32 | APB read data; switch event flags in bits 1:0 |
| pReady | output | 1 | Always-ready response |
| pSlvErr | output | 1 | Error response, always 0 |
| swIn | input | 2 | Raw asynchronous switch lines |
| ledOut | output | 8 | One-hot LED drive |
| irqMain | output | 1 | Single-cycle event interrupt pulse |
| irqCopy | output | 1 | Duplicate of irqMain |

## Verification
The bench builds the block with its default parameters: two switch lines, eight LEDs over a 32-bit data bus, and three synchronizer stages. With three stages the pulse falls at a fixed third edge after a switch rises. This lets the bench place a clearing read exactly on the event edge and test that the flag is kept. It also lets the bench make a one-edge glitch that must not fill the chain. Eight LEDs make both ends of the decode reachable, with bits above the select field set to check that they are ignored.

// File: rtl/swirq_pkg.sv
package swirq_pkg;

  // Strobes from bus control to the datapath, one per access kind.
  typedef struct packed {
    logic ledLoad;      // write access phase: load LED decode
    logic statusClear;  // read access phase: clear event flags
  } ctrlStrobes_t;

endpackage

// File: rtl/swirq_ctrl.sv
module swirq_ctrl
  import swirq_pkg::*;
(
  input  logic         pSel,
  input  logic         pEnable,
  input  logic         pWrite,
  output ctrlStrobes_t strobes,
  output logic         pReady,
  output logic         pSlvErr
);

  logic accessPhase;

  // Single register location: every access phase completes in one cycle.
  assign accessPhase         = pSel & pEnable;
  assign strobes.ledLoad     = accessPhase & pWrite;
  assign strobes.statusClear = accessPhase & ~pWrite;

  assign pReady  = 1'b1;
  assign pSlvErr = 1'b0;

endmodule

// File: rtl/swirq_sync.sv
module swirq_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic swAsync,
  output logic evt
);

  logic [STAGES-1:0] chain;

  // A low switch line empties the chain at once; a high line fills it
  // from the bottom one stage per edge.
  always_ff @(posedge clk or negedge swAsync) begin
    if (!swAsync) chain <= '0;
    else          chain <= {chain[STAGES-2:0], 1'b1};
  end

  // Event: the fill has reached the next-to-last stage but not the last.
  assign evt = chain[STAGES-2] & ~chain[STAGES-1];

endmodule

// File: rtl/swirq_datapath.sv
module swirq_datapath
  import swirq_pkg::*;
#(
  parameter int NUM_SW      = 2,
  parameter int NUM_LED     = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 3
) (
  input  logic              pClk,
  input  logic              pResetN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] pWData,
  input  logic [NUM_SW-1:0] swIn,
  output logic [DATA_W-1:0] pRData,
  output logic [NUM_LED-1:0] ledOut,
  output logic              irqOut
);

  localparam int SEL_W = $clog2(NUM_LED);

  logic [NUM_SW-1:0]  swEvt;
  logic [NUM_SW-1:0]  statusReg;
  logic [NUM_LED-1:0] ledReg;
  logic               irqReg;
  logic               anyEvt;
  logic               unusedWdata;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SW; gi++) begin : g_sync
      swirq_sync #(.STAGES(SYNC_STAGES)) uSync (
        .clk     (pClk),
        .swAsync (swIn[gi]),
        .evt     (swEvt[gi])
      );
    end
  endgenerate

  // Priority scan from switch 0 upward; any hit yields the single pulse.
  always_comb begin
    anyEvt = 1'b0;
    for (int i = 0; i < NUM_SW; i++) begin
      if (!anyEvt && swEvt[i]) anyEvt = 1'b1;
    end
  end

  always_ff @(posedge pClk or negedge pResetN) begin
    if (!pResetN) begin
      ledReg    <= '0;
      statusReg <= '0;
      irqReg    <= 1'b0;
    end else begin
      if (strobes.ledLoad)
        ledReg <= NUM_LED'(1) << pWData[SEL_W-1:0];
      // Clearing read and new events at one edge: the new events win.
      statusReg <= (strobes.statusClear ? '0 : statusReg) | swEvt;
      irqReg    <= anyEvt;
    end
  end

  assign unusedWdata = ^pWData[DATA_W-1:SEL_W];
  assign pRData      = DATA_W'(statusReg);
  assign ledOut      = ledReg;
  assign irqOut      = irqReg;

endmodule

// File: rtl/switch_irq_apb.sv
module switch_irq_apb
  import swirq_pkg::*;
#(
  parameter int NUM_SW      = 2,
  parameter int NUM_LED     = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 3
) (
  input  logic               pClk,
  input  logic               pResetN,
  input  logic               pSel,
  input  logic               pEnable,
  input  logic               pWrite,
  input  logic [DATA_W-1:0]  pWData,
  output logic [DATA_W-1:0]  pRData,
  output logic               pReady,
  output logic               pSlvErr,
  input  logic [NUM_SW-1:0]  swIn,
  output logic [NUM_LED-1:0] ledOut,
  output logic               irqMain,
  output logic               irqCopy
);

  ctrlStrobes_t strobes;
  logic         irqPulse;

  swirq_ctrl uCtrl (
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .strobes (strobes),
    .pReady  (pReady),
    .pSlvErr (pSlvErr)
  );

  swirq_datapath #(
    .NUM_SW      (NUM_SW),
    .NUM_LED     (NUM_LED),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .pClk    (pClk),
    .pResetN (pResetN),
    .strobes (strobes),
    .pWData  (pWData),
    .swIn    (swIn),
    .pRData  (pRData),
    .ledOut  (ledOut),
    .irqOut  (irqPulse)
  );

  assign irqMain = irqPulse;
  assign irqCopy = irqPulse;

endmodule

// File: rtl/swirq_checker.sv
module swirq_checker #(
  parameter int NUM_SW  = 2,
  parameter int NUM_LED = 8,
  parameter int DATA_W  = 32
) (
  input logic               pClk,
  input logic               pResetN,
  input logic               pSel,
  input logic               pEnable,
  input logic               pWrite,
  input logic [DATA_W-1:0]  pWData,
  input logic [DATA_W-1:0]  pRData,
  input logic [NUM_SW-1:0]  swIn,
  input logic [NUM_LED-1:0] ledOut,
  input logic               irqMain
);

  localparam int SEL_W = $clog2(NUM_LED);

  logic wrAcc, rdAcc;
  assign wrAcc = pSel & pEnable & pWrite;
  assign rdAcc = pSel & pEnable & ~pWrite;

  assert_led_onehot_R2: assert property (@(posedge pClk) disable iff (!pResetN)
    $onehot0(ledOut));

  assert_led_decode_R2: assert property (@(posedge pClk) disable iff (!pResetN)
    wrAcc |=> ledOut == (NUM_LED'(1) << $past(pWData[SEL_W-1:0])));

  assert_led_hold_R3: assert property (@(posedge pClk) disable iff (!pResetN)
    !wrAcc |=> $stable(ledOut));

  assert_irq_flags_R8: assert property (@(posedge pClk) disable iff (!pResetN)
    irqMain |-> pRData != '0);

  assert_flags_sticky_R8: assert property (@(posedge pClk) disable iff (!pResetN)
    !rdAcc |=> (($past(pRData) & ~pRData) == '0));

  // R9 with R10: after a clearing read only a fresh event may leave a flag.
  assert_read_clear_R9: assert property (@(posedge pClk) disable iff (!pResetN)
    rdAcc |=> (pRData == '0 || irqMain));

  assert_low_no_irq_R6: assert property (@(posedge pClk) disable iff (!pResetN)
    (swIn == '0) |=> !irqMain);

endmodule

bind switch_irq_apb swirq_checker #(
  .NUM_SW  (NUM_SW),
  .NUM_LED (NUM_LED),
  .DATA_W  (DATA_W)
) uChk (
  .pClk    (pClk),
  .pResetN (pResetN),
  .pSel    (pSel),
  .pEnable (pEnable),
  .pWrite  (pWrite),
  .pWData  (pWData),
  .pRData  (pRData),
  .swIn    (swIn),
  .ledOut  (ledOut),
  .irqMain (irqMain)
);

// File: tb/tb_switch_irq_apb.sv
module tb_switch_irq_apb;

  localparam int CLK_PERIOD = 10;

  typedef enum int {OBS_LED, OBS_RDATA, OBS_IRQ, OBS_COPY, OBS_RESP} obsKind_t;
  typedef struct {
    string       req;
    obsKind_t    kind;
    logic [31:0] exp;
  } expItem_t;

  logic        pClk = 1'b0;
  logic        pResetN = 1'b0;
  logic        pSel = 1'b0;
  logic        pEnable = 1'b0;
  logic        pWrite = 1'b0;
  logic [31:0] pWData = '0;
  logic [31:0] pRData;
  logic        pReady;
  logic        pSlvErr;
  logic [1:0]  swIn = 2'b00;
  logic [7:0]  ledOut;
  logic        irqMain;
  logic        irqCopy;

  expItem_t expQ[$];
  int       vectors = 0;
  int       miscompares = 0;
  bit       done = 1'b0;

  switch_irq_apb dut (
    .pClk    (pClk),
    .pResetN (pResetN),
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .pWData  (pWData),
    .pRData  (pRData),
    .pReady  (pReady),
    .pSlvErr (pSlvErr),
    .swIn    (swIn),
    .ledOut  (ledOut),
    .irqMain (irqMain),
    .irqCopy (irqCopy)
  );

  always #(CLK_PERIOD/2) pClk = ~pClk;

  function automatic logic [31:0] observe(obsKind_t k);
    case (k)
      OBS_LED:   return {24'd0, ledOut};
      OBS_RDATA: return pRData;
      OBS_IRQ:   return {31'd0, irqMain};
      OBS_COPY:  return {31'd0, irqCopy};
      default:   return {30'd0, pSlvErr, pReady};
    endcase
  endfunction

  // Items pushed at a falling edge are compared just after it.
  task automatic pushExp(obsKind_t k, logic [31:0] v, string req);
    expQ.push_back('{req, k, v});
  endtask

  // Monitor: pops expectations and compares them against the ports.
  initial begin
    forever begin
      @(negedge pClk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it  = expQ.pop_front();
        act = observe(it.kind);
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s (%s): actual %h expected %h", it.req, it.kind.name(), act, it.exp);
        end
      end
    end
  end

  task automatic apbWrite(input logic [31:0] d);
    @(negedge pClk); pSel = 1'b1; pWrite = 1'b1; pWData = d; pEnable = 1'b0;
    @(negedge pClk); pEnable = 1'b1;
    @(negedge pClk); pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  task automatic apbRead(input logic [31:0] exp, input string req);
    @(negedge pClk); pSel = 1'b1; pWrite = 1'b0; pEnable = 1'b0;
    @(negedge pClk); pEnable = 1'b1;
    pushExp(OBS_RDATA, exp, req);
    pushExp(OBS_RESP, 32'd1, "R12");
    @(negedge pClk); pSel = 1'b0; pEnable = 1'b0;
  endtask

  // Drive switches at a falling edge; the pulse must follow the third rise.
  task automatic swEvent(input logic [1:0] s, input string req);
    @(negedge pClk); swIn = s;
    @(negedge pClk);
    @(negedge pClk); pushExp(OBS_IRQ, 32'd0, req);
    @(negedge pClk); pushExp(OBS_IRQ, 32'd1, req); pushExp(OBS_COPY, 32'd1, "R11");
    @(negedge pClk); pushExp(OBS_IRQ, 32'd0, "R5");  pushExp(OBS_COPY, 32'd0, "R11");
  endtask

  task automatic quietCycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge pClk); pushExp(OBS_IRQ, 32'd0, req);
    end
  endtask

  initial begin
    // R1: state in and just after reset
    repeat (3) @(negedge pClk);
    pushExp(OBS_LED, 32'd0, "R1");
    pushExp(OBS_IRQ, 32'd0, "R1");
    @(negedge pClk); pResetN = 1'b1;
    @(negedge pClk);
    pushExp(OBS_LED, 32'd0, "R1");
    pushExp(OBS_RDATA, 32'd0, "R1");
    pushExp(OBS_IRQ, 32'd0, "R1");
    pushExp(OBS_COPY, 32'd0, "R1");
    pushExp(OBS_RESP, 32'd1, "R12");

    // R2: decode of the low three bits, upper bits ignored
    apbWrite(32'h0000_0003); pushExp(OBS_LED, 32'h08, "R2");
    apbWrite(32'hFFFF_FFF5); pushExp(OBS_LED, 32'h20, "R2");
    apbWrite(32'h0000_0000); pushExp(OBS_LED, 32'h01, "R2");
    apbWrite(32'h0000_0007); pushExp(OBS_LED, 32'h80, "R2");

    // R4/R8: switch 0 event timing and flag
    swEvent(2'b01, "R4");
    apbRead(32'd1, "R8");
    apbRead(32'd0, "R9");
    pushExp(OBS_LED, 32'h80, "R3");

    // R5: held high, then released: no pulse either way
    quietCycles(5, "R5");
    @(negedge pClk); swIn = 2'b00;
    quietCycles(4, "R5");
    apbRead(32'd0, "R5");

    // R8: switch 1 maps to bit 1 and stays until read
    swEvent(2'b10, "R4");
    quietCycles(3, "R8");
    apbRead(32'd2, "R8");
    @(negedge pClk); swIn = 2'b00;

    // R7: both switches together
    swEvent(2'b11, "R7");
    apbRead(32'd3, "R7");
    pushExp(OBS_LED, 32'h80, "R3");
    @(negedge pClk); swIn = 2'b00;

    // R6: high for only one rising edge
    @(negedge pClk); swIn = 2'b01;
    @(negedge pClk); swIn = 2'b00;
    quietCycles(4, "R6");
    apbRead(32'd0, "R6");

    // R10: event lands on the edge of a clearing read
    @(negedge pClk); swIn = 2'b10;
    @(negedge pClk); pSel = 1'b1; pWrite = 1'b0; pEnable = 1'b0;
    @(negedge pClk); pEnable = 1'b1; pushExp(OBS_RDATA, 32'd0, "R10");
    @(negedge pClk); pSel = 1'b0; pEnable = 1'b0;
    pushExp(OBS_IRQ, 32'd1, "R10");
    pushExp(OBS_COPY, 32'd1, "R11");
    apbRead(32'd2, "R10");
    apbRead(32'd0, "R9");
    @(negedge pClk); swIn = 2'b00;

    // R2: lowest position after activity
    apbWrite(32'h0000_0100); pushExp(OBS_LED, 32'h01, "R2");

    repeat (3) @(negedge pClk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pClk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule